// File: doc/BRIEF.md
# Hot-Code Remapping Bus Codec

This block is a transmit and receive pair for a wide on-chip data bus whose traffic often swings between the all-zeros word and the all-ones word. On the transmit side, a fixed pair of codes trades places. The hot word is all-ones by default, and it goes onto the bus as the swap word, which is 00..01 by default. The swap word in turn goes onto the bus as the hot word. Every other word is sent unchanged. A swing from all-zeros to all-ones therefore moves a single bus wire instead of every wire.

The receive side applies the same exchange, because the swap is its own inverse. The word it delivers is therefore the word that was sent. Both sides register their output and carry a valid qualifier, so each side adds one cycle of latency. Each side keeps its last word while its input valid is low, so an idle bus does not toggle. The two codes and the width are parameters and are checked at elaboration.

Top module: `hcr_bus_codec`

## Requirements
- R1: During and right after reset, `bus_valid` and `out_valid` are 0, and `bus_data` and `out_data` are all zeros.
- R2: A valid all-ones input word (the hot word) appears on `bus_data` as 00..01 (only bit 0 set) one clock later.
- R3: A valid 00..01 input word appears on `bus_data` as all-ones one clock later, so the mapping never aliases.
- R4: A valid input word that is neither all-ones nor 00..01 appears unchanged on `bus_data` one clock later.
- R5: `out_data` equals the input word accepted two clocks earlier whenever `out_valid` is 1, for every input value.
- R6: `bus_valid` equals `in_valid` delayed by one clock, and `out_valid` equals `bus_valid` delayed by one clock.
- R7: While `in_valid` is 0, `bus_data` keeps its previous value. While `bus_valid` is 0, `out_data` keeps its previous value.
- R8: On a stream that alternates between all-zeros and all-ones words, each transfer toggles exactly one `bus_data` wire. The total is fewer toggles than the raw input stream makes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | WIDTH | Raw word to send |
| bus_valid | output | 1 | Qualifier on the long bus |
| bus_data | output | WIDTH | Remapped word on the long bus |
| out_valid | output | 1 | Receive-side output qualifier |
| out_data | output | WIDTH | Restored word |

## Verification
The bench aims at the two remap codes sent back to back and mixed with random words. A one-way mapping would return all-ones wherever 00..01 was sent, and a mapping with the pair swapped the wrong way would fail on both codes. Idle gaps check that neither side updates or toggles while its valid is low; a register that loads without regard to valid would show a changed word after a gap. A long alternating all-zeros/all-ones stream counts bus toggles against the raw stream. That run exposes a codec that passes words through untouched or that moves more than one wire per swing.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

   // Default bus width for the codec family
   localparam int unsigned HCR_DEF_WIDTH = 32;

   // Classification of a word against the two remap codes
   typedef enum logic [1:0] {
      HCR_PASS = 2'd0,
      HCR_HOT  = 2'd1,
      HCR_SWAP = 2'd2
   } hcr_match_e;

endpackage

// File: rtl/hcr_swap.sv
module hcr_swap
   import hcr_pkg::*;
#(
   parameter int unsigned           WIDTH     = HCR_DEF_WIDTH,
   parameter logic [WIDTH-1:0]      HOT_WORD  = '1,
   parameter logic [WIDTH-1:0]      SWAP_WORD = {{(WIDTH-1){1'b0}}, 1'b1}
) (
   input  logic [WIDTH-1:0] word_i,
   output logic [WIDTH-1:0] word_o,
   output hcr_match_e       kind_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("hcr_swap: WIDTH must be at least 2");
      end
      if (HOT_WORD == SWAP_WORD) begin : g_bad_codes
         $error("hcr_swap: the two remap codes must differ");
      end
   endgenerate

   always_comb begin
      if (word_i == HOT_WORD)       kind_o = HCR_HOT;
      else if (word_i == SWAP_WORD) kind_o = HCR_SWAP;
      else                          kind_o = HCR_PASS;
   end

   always_comb begin
      unique case (kind_o)
         HCR_HOT:  word_o = SWAP_WORD;
         HCR_SWAP: word_o = HOT_WORD;
         default:  word_o = word_i;
      endcase
   end

endmodule

// File: rtl/hcr_hold_reg.sv
module hcr_hold_reg #(
   parameter int unsigned WIDTH = hcr_pkg::HCR_DEF_WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] data_i,
   output logic             valid_o,
   output logic [WIDTH-1:0] data_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
      end else begin
         valid_o <= load_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
      end else if (load_i) begin
         data_o <= data_i;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(data_o)); // R7
   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> valid_o); // R6
   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> !valid_o); // R6

endmodule

// File: rtl/hcr_codec_side.sv
module hcr_codec_side
   import hcr_pkg::*;
#(
   parameter int unsigned      WIDTH     = HCR_DEF_WIDTH,
   parameter logic [WIDTH-1:0] HOT_WORD  = '1,
   parameter logic [WIDTH-1:0] SWAP_WORD = {{(WIDTH-1){1'b0}}, 1'b1}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [WIDTH-1:0] data_i,
   output logic             valid_o,
   output logic [WIDTH-1:0] data_o
);

   logic [WIDTH-1:0] mapped;
   hcr_match_e       kind;

   hcr_swap #(
      .WIDTH     (WIDTH),
      .HOT_WORD  (HOT_WORD),
      .SWAP_WORD (SWAP_WORD)
   ) u_swap (
      .word_i (data_i),
      .word_o (mapped),
      .kind_o (kind)
   );

   hcr_hold_reg #(
      .WIDTH (WIDTH)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (valid_i),
      .data_i  (mapped),
      .valid_o (valid_o),
      .data_o  (data_o)
   );

   AST_HOT_TO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && data_i == HOT_WORD) |=> (data_o == SWAP_WORD)); // R2
   AST_SWAP_TO_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && data_i == SWAP_WORD) |=> (data_o == HOT_WORD)); // R3
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && data_i != HOT_WORD && data_i != SWAP_WORD)
      |=> (data_o == $past(data_i))); // R4

endmodule

// File: rtl/hcr_bus_codec.sv
module hcr_bus_codec
   import hcr_pkg::*;
#(
   parameter int unsigned      WIDTH     = HCR_DEF_WIDTH,
   parameter logic [WIDTH-1:0] HOT_WORD  = '1,
   parameter logic [WIDTH-1:0] SWAP_WORD = {{(WIDTH-1){1'b0}}, 1'b1}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   output logic             bus_valid,
   output logic [WIDTH-1:0] bus_data,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data
);

   // Transmit side: remap then register onto the long bus
   hcr_codec_side #(
      .WIDTH     (WIDTH),
      .HOT_WORD  (HOT_WORD),
      .SWAP_WORD (SWAP_WORD)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid),
      .data_i  (in_data),
      .valid_o (bus_valid),
      .data_o  (bus_data)
   );

   // Receive side: the swap is an involution, so the same side restores the word
   hcr_codec_side #(
      .WIDTH     (WIDTH),
      .HOT_WORD  (HOT_WORD),
      .SWAP_WORD (SWAP_WORD)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (bus_valid),
      .data_i  (bus_data),
      .valid_o (out_valid),
      .data_o  (out_data)
   );

   AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data == $past(in_data, 2))); // R5
   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid, 2) |-> out_valid); // R6
   AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !bus_valid) |=> $stable(out_data)); // R7

endmodule

// File: tb/hcr_bus_codec_tb.sv
module hcr_bus_codec_tb;

   localparam int W = 32;
   localparam logic [W-1:0] ONES = '1;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         bus_valid, out_valid;
   logic [W-1:0] bus_data, out_data;

   int checks = 0;
   int errors = 0;

   // behavioural model state
   logic         m_bus_v = 1'b0, m_out_v = 1'b0;
   logic [W-1:0] m_bus = '0, m_out = '0;
   logic [W-1:0] prev_bus_seen = '0;
   logic [W-1:0] prev_raw = '0;
   int           enc_toggles = 0, raw_toggles = 0;
   bit           counting = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   hcr_bus_codec #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .bus_valid(bus_valid), .bus_data(bus_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [W-1:0] remap(input logic [W-1:0] d);
      if (d == ONES) return ONE;        // hot word to swap word
      else if (d == ONE) return ONES;   // swap word to hot word
      return d;
   endfunction

   function automatic string tag_for(input logic [W-1:0] d);
      if (d == ONES) return "R2";
      if (d == ONE)  return "R3";
      return "R4";
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // drive one cycle at the negedge, compare shortly after the next posedge
   task automatic cycle(input logic v, input logic [W-1:0] d);
      logic [W-1:0] n_bus, n_out;
      logic         n_bus_v, n_out_v;
      string        btag;
      in_valid = v;
      in_data  = d;
      btag = v ? tag_for(d) : "R7";
      n_bus_v = v;
      n_bus   = v ? remap(d) : m_bus;
      n_out_v = m_bus_v;
      n_out   = m_bus_v ? remap(m_bus) : m_out;
      @(posedge clk);
      #1;
      m_bus_v = n_bus_v; m_bus = n_bus; m_out_v = n_out_v; m_out = n_out;
      check("R6", {31'b0, bus_valid}, {31'b0, m_bus_v});
      check("R6", {31'b0, out_valid}, {31'b0, m_out_v});
      check(btag, bus_data, m_bus);
      check(m_out_v ? "R5" : "R7", out_data, m_out);
      if (counting) begin
         enc_toggles += $countones(bus_data ^ prev_bus_seen);
         if (v) begin
            raw_toggles += $countones(d ^ prev_raw);
            prev_raw = d;
         end
      end
      prev_bus_seen = bus_data;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", {31'b0, bus_valid}, '0);
      check("R1", {31'b0, out_valid}, '0);
      check("R1", bus_data, '0);
      check("R1", out_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", bus_data, '0);
      check("R1", out_data, '0);

      // R2 and R3: the two codes, back to back and repeated
      cycle(1'b1, ONES);
      cycle(1'b1, ONE);
      cycle(1'b1, ONE);
      cycle(1'b1, ONES);
      cycle(1'b1, 32'h0000_0002);
      cycle(1'b1, 32'hFFFF_FFFE);
      cycle(1'b1, 32'h8000_0000);
      cycle(1'b1, '0);
      cycle(1'b0, '0);
      cycle(1'b0, '0);

      // R4 and R5: random words mixed with codes, R7: gaps with garbage data
      for (int i = 0; i < 400; i++) begin
         int unsigned r = $urandom % 8;
         logic [W-1:0] w = $urandom;
         if (r == 0) w = ONES;
         else if (r == 1) w = ONE;
         cycle((r != 7), (r == 7) ? ONES : w);
      end
      cycle(1'b1, 32'h1234_5678);
      cycle(1'b0, ONE);
      cycle(1'b0, ONES);
      check("R7", bus_data, 32'h1234_5678);
      check("R7", out_data, 32'h1234_5678);

      // R8: alternating all-zeros and all-ones stream
      cycle(1'b1, '0);
      cycle(1'b0, '0);
      prev_raw = '0;
      counting = 1'b1;
      for (int i = 0; i < 40; i++) cycle(1'b1, (i % 2 == 0) ? ONES : '0);
      counting = 1'b0;
      check("R8", enc_toggles, 40);
      check("R8", raw_toggles, 40 * W);
      checks++;
      if (!(enc_toggles < raw_toggles)) begin
         errors++;
         $display("FAIL R8 actual=%0d expected below %0d", enc_toggles, raw_toggles);
      end
      cycle(1'b0, '0);
      cycle(1'b0, '0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule